// File: doc/BRIEF.md
# Masked Multichannel ADC Scan Sequencer

This block sequences software-started conversions across up to sixteen analog channels. A 16-bit select mask names the channels that take part. A one-cycle start strobe captures the mask and begins the scan at the lowest selected channel. The scan then moves upward one selected channel at a time, and clear mask bits are passed over. The block drives an external converter core through a simple handshake. It holds `conv_start_o` high and `conv_chan_o` steady until the core pulses `conv_done_i` together with the result. That result is pushed at once into a downstream buffer, tagged with its channel number.

If a start strobe arrives while a scan is running, the current conversion is abandoned and its result is thrown away. The core's start line drops for one cycle. The scan then begins again from the bottom of the newly captured mask. With a single selected channel, this repeats the conversion of that same channel. When the last selected channel finishes, busy clears and a sticky end-of-scan flag is raised. Software clears the flag by writing a 1 to it. The interrupt output is that flag gated by an enable bit.

The controller has four states:

| State | Meaning | Transitions |
|-------|---------|-------------|
| S_IDLE | Waiting for a start strobe. | A start with a non-empty mask goes to S_CONV. A start with an empty mask stays here and raises end-of-scan. |
| S_CONV | Converting the current channel. | On done with more selected channels above, it pushes the result and goes to S_STEP. On done at the last channel, it pushes the result and goes to S_IDLE, raising end-of-scan. A start strobe goes to S_RESTART. |
| S_STEP | Start is held low for one cycle between two channels. | Goes to S_CONV. |
| S_RESTART | Start is held low for one cycle after an abort. | Goes to S_CONV. |

From S_CONV, S_STEP or S_RESTART, a start strobe with an empty mask ends the scan: the block goes to S_IDLE and raises end-of-scan.

Top module: `adc_scan_seq`

## Requirements
- R1: Every channel whose mask bit is 1 is converted exactly once per scan, in ascending channel order. Channels with a clear bit are skipped. Each result is pushed (`push_o` high for one cycle) in the cycle the core's done arrives, with `push_chan_o` equal to the channel and `push_data_o` equal to `conv_data_i`.
- R2: `busy_o` is 1 in the cycle after a start strobe with a non-empty mask. It returns to 0 in the cycle after the last selected channel's result is pushed.
- R3: `eos_o` is set in the cycle after the last result of a scan is pushed. It stays 1 until a cycle with `eos_clr_i` high, after which it is 0. If a set and a clear arrive in the same cycle, the set wins.
- R4: `irq_o` is 1 exactly when `eos_o` is 1 and `irq_en_i` is 1.
- R5: A start strobe during a scan drives `conv_start_o` low in the next cycle. The scan then restarts from the lowest selected channel of the mask presented with that strobe.
- R6: With one channel selected, a start strobe during its conversion makes that same channel convert again, and only one result is pushed.
- R7: The result of an aborted conversion is never pushed, even when `conv_done_i` arrives in the same cycle as the start strobe.
- R8: A start strobe with an all-zero mask sets `eos_o` in the next cycle. No conversion starts, no result is pushed and `busy_o` stays 0.
- R9: After reset, `busy_o`, `eos_o`, `irq_o`, `conv_start_o` and `push_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start strobe; captures `mask_i` |
| mask_i | input | 16 | Channel select mask; bit n selects channel n |
| irq_en_i | input | 1 | Interrupt enable |
| eos_clr_i | input | 1 | Clears the end-of-scan flag when 1 |
| busy_o | output | 1 | A scan is in progress |
| eos_o | output | 1 | Sticky end-of-scan flag |
| irq_o | output | 1 | End-of-scan interrupt |
| conv_start_o | output | 1 | Converter start, held high during a conversion |
| conv_chan_o | output | 4 | Channel being converted |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 10 | Converter result, valid with done |
| push_o | output | 1 | Result buffer write strobe |
| push_chan_o | output | 4 | Channel of the pushed result |
| push_data_o | output | 10 | Pushed result |

## Verification
The assertions assume that the converter core pulses `conv_done_i` only while `conv_start_o` is high. They also assume that `start_i` and `eos_clr_i` are single-cycle strobes driven between clock edges. The bench's core model counts a fixed latency only while start is high, and resets that count whenever start drops. All strobes are driven at the falling edge for exactly one cycle. The aborted-result case is placed deliberately so that the strobe lands in the very cycle the model raises done.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_CONV,
        S_STEP,
        S_RESTART
    } scan_state_t;
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask_i,
    input  logic [CW:0]    base_i,
    output logic           found_o,
    output logic [CW-1:0]  idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i] && (i >= int'(base_i))) begin
                found_o = 1'b1;
                idx_o   = i[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/eos_status.sv
module eos_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic eos_o,
    output logic irq_o
);
    logic eos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     eos_q <= 1'b0;
        else if (set_i) eos_q <= 1'b1;
        else if (clr_i) eos_q <= 1'b0;
    end

    assign eos_o = eos_q;
    assign irq_o = eos_q & en_i;

    // R3
    eos_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> eos_o);
    // R3
    eos_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !eos_o);
    // R3
    eos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_o && !clr_i) |=> eos_o);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 10,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           irq_en_i,
    input  logic           eos_clr_i,
    output logic           busy_o,
    output logic           eos_o,
    output logic           irq_o,
    output logic           conv_start_o,
    output logic [CW-1:0]  conv_chan_o,
    input  logic           conv_done_i,
    input  logic [DW-1:0]  conv_data_i,
    output logic           push_o,
    output logic [CW-1:0]  push_chan_o,
    output logic [DW-1:0]  push_data_o
);
    scan_state_t    state_q, state_d;
    logic [NCH-1:0] mask_q, mask_d;
    logic [CW-1:0]  chan_q, chan_d;
    logic           eos_set, push_d;
    logic           first_found, next_found;
    logic [CW-1:0]  first_idx, next_idx;
    logic [CW:0]    next_base;

    assign next_base = {1'b0, chan_q} + 1'b1;

    lowest_pick #(.NCH(NCH)) u_first (
        .mask_i(mask_i), .base_i('0),
        .found_o(first_found), .idx_o(first_idx)
    );

    lowest_pick #(.NCH(NCH)) u_next (
        .mask_i(mask_q), .base_i(next_base),
        .found_o(next_found), .idx_o(next_idx)
    );

    eos_status u_status (
        .clk(clk), .rst_n(rst_n), .set_i(eos_set), .clr_i(eos_clr_i),
        .en_i(irq_en_i), .eos_o(eos_o), .irq_o(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mask_q  <= '0;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            chan_q  <= chan_d;
        end
    end

    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        chan_d  = chan_q;
        eos_set = 1'b0;
        push_d  = 1'b0;
        if (start_i) begin
            mask_d = mask_i;
            if (!first_found) begin
                state_d = S_IDLE;
                eos_set = 1'b1;
            end else begin
                chan_d  = first_idx;
                state_d = (state_q == S_IDLE) ? S_CONV : S_RESTART;
            end
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_CONV: begin
                    if (conv_done_i) begin
                        push_d = 1'b1;
                        if (next_found) begin
                            chan_d  = next_idx;
                            state_d = S_STEP;
                        end else begin
                            state_d = S_IDLE;
                            eos_set = 1'b1;
                        end
                    end
                end
                S_STEP, S_RESTART: state_d = S_CONV;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o       = (state_q != S_IDLE);
        conv_start_o = (state_q == S_CONV);
        conv_chan_o  = chan_q;
        push_o       = push_d;
        push_chan_o  = chan_q;
        push_data_o  = conv_data_i;
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!conv_start_o && !push_o));
    // R5
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !conv_start_o);
    // R7
    no_abort_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !push_o);
    // R1
    push_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> mask_q[push_chan_o]);
    // R1
    chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && $past(conv_start_o)) |-> $stable(conv_chan_o));
    // R8
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mask_i == '0) |=> (eos_o && !busy_o));
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
    localparam int CLK_NS = 10;
    localparam int LAT    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic        irq_en_i = 1'b0;
    logic        eos_clr_i = 1'b0;
    logic        busy_o, eos_o, irq_o, conv_start_o, push_o;
    logic [3:0]  conv_chan_o, push_chan_o;
    logic        conv_done_i = 1'b0;
    logic [9:0]  conv_data_i;
    logic [9:0]  push_data_o;

    int errors = 0;
    int checks = 0;
    logic [5:0] seed = 6'h00;
    int   cnt = 0;

    int         log_n = 0;
    logic [3:0] log_chan [0:31];
    logic [9:0] log_data [0:31];

    always #(CLK_NS / 2) clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .irq_en_i(irq_en_i), .eos_clr_i(eos_clr_i), .busy_o(busy_o),
        .eos_o(eos_o), .irq_o(irq_o), .conv_start_o(conv_start_o),
        .conv_chan_o(conv_chan_o), .conv_done_i(conv_done_i),
        .conv_data_i(conv_data_i), .push_o(push_o),
        .push_chan_o(push_chan_o), .push_data_o(push_data_o)
    );

    assign conv_data_i = {seed, conv_chan_o};

    always @(posedge clk) begin
        if (!rst_n || !conv_start_o) begin
            cnt <= 0;
            conv_done_i <= 1'b0;
        end else begin
            conv_done_i <= (cnt == LAT - 1);
            if (cnt < LAT) cnt <= cnt + 1;
        end
    end

    always @(posedge clk) begin
        if (rst_n && push_o && log_n < 32) begin
            log_chan[log_n] <= push_chan_o;
            log_data[log_n] <= push_data_o;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [15:0] m);
        @(negedge clk);
        mask_i  = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_o);
        @(negedge clk);
    endtask

    task automatic clear_eos();
        @(negedge clk);
        eos_clr_i = 1'b1;
        @(negedge clk);
        eos_clr_i = 1'b0;
    endtask

    task automatic check_log(input logic [15:0] m, input string tag);
        int exp_n = 0;
        for (int c = 0; c < 16; c++) begin
            if (m[c]) begin
                if (exp_n < log_n) begin
                    chk(log_chan[exp_n] == 4'(c), {tag, " channel order"}, int'(log_chan[exp_n]), c);
                    chk(log_data[exp_n] == {seed, 4'(c)}, {tag, " pushed data"},
                        int'(log_data[exp_n]), int'({seed, 4'(c)}));
                end
                exp_n++;
            end
        end
        chk(log_n == exp_n, {tag, " push count"}, log_n, exp_n);
    endtask

    task automatic t_reset();
        chk(!busy_o, "R9 busy after reset", busy_o, 0);
        chk(!eos_o, "R9 eos after reset", eos_o, 0);
        chk(!irq_o, "R9 irq after reset", irq_o, 0);
        chk(!conv_start_o && !push_o, "R9 start/push after reset", conv_start_o, 0);
    endtask

    task automatic t_scan(input logic [15:0] m, input logic [5:0] s);
        seed = s;
        log_n = 0;
        pulse_start(m);
        chk(busy_o, "R2 busy after start", busy_o, 1);
        wait_idle();
        chk(!busy_o, "R2 busy cleared at end", busy_o, 0);
        chk(eos_o, "R3 eos set at end", eos_o, 1);
        check_log(m, "R1");
        clear_eos();
        chk(!eos_o, "R3 eos cleared", eos_o, 0);
    endtask

    task automatic t_irq();
        irq_en_i = 1'b0;
        seed = 6'h11;
        log_n = 0;
        pulse_start(16'h0002);
        wait_idle();
        chk(eos_o && !irq_o, "R4 irq masked", irq_o, 0);
        @(negedge clk);
        irq_en_i = 1'b1;
        #1;
        chk(irq_o, "R4 irq enabled", irq_o, 1);
        clear_eos();
        chk(!irq_o, "R4 irq after clear", irq_o, 0);
        irq_en_i = 1'b0;
    endtask

    task automatic t_restart_multi();
        seed = 6'h2A;
        log_n = 0;
        pulse_start(16'h00F0);
        while (log_n < 2) @(negedge clk);
        log_n = 0;
        seed = 6'h15;
        mask_i = 16'h0300;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!conv_start_o, "R5 start low after restart", conv_start_o, 0);
        wait_idle();
        check_log(16'h0300, "R5");
        clear_eos();
    endtask

    task automatic t_restart_single();
        seed = 6'h07;
        log_n = 0;
        pulse_start(16'h0008);
        repeat (2) @(negedge clk);
        chk(conv_chan_o == 4'd3, "R6 channel before restart", conv_chan_o, 3);
        seed = 6'h3C;
        pulse_start(16'h0008);
        chk(!conv_start_o, "R6 start low after restart", conv_start_o, 0);
        wait_idle();
        check_log(16'h0008, "R6");
        clear_eos();
    endtask

    task automatic t_abort_coincident();
        seed = 6'h21;
        log_n = 0;
        pulse_start(16'h0003);
        while (!conv_done_i) @(negedge clk);
        log_n = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(log_n == 0, "R7 aborted result not pushed", log_n, 0);
        wait_idle();
        check_log(16'h0003, "R7");
        clear_eos();
    endtask

    task automatic t_empty();
        log_n = 0;
        @(negedge clk);
        mask_i = 16'h0000;
        start_i = 1'b1;
        eos_clr_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        eos_clr_i = 1'b0;
        chk(eos_o, "R8 eos on empty mask (set beats clear, R3)", eos_o, 1);
        chk(!busy_o, "R8 busy stays low", busy_o, 0);
        repeat (LAT + 2) @(negedge clk);
        chk(log_n == 0 && !conv_start_o, "R8 nothing converted", log_n, 0);
        clear_eos();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan(16'h0020, 6'h05);
        t_scan(16'h8421, 6'h19);
        t_scan(16'hFFFF, 6'h33);
        t_scan(16'h8000, 6'h0E);
        t_irq();
        t_restart_multi();
        t_restart_single();
        t_abort_coincident();
        t_empty();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: scan never finished, actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule